// File: doc/BRIEF.md
# Round-Masked AES-256 Iterative Cipher Core

This core runs one 128-bit block through fourteen cipher rounds, one round per clock cycle, in either the encrypting or the decrypting direction. The substitution step is not a fixed table. Each round supplies two mask bytes. The first mask is XORed into every state byte before the standard AES forward S-box, and the second is XORed into the S-box output. As a result, the same input byte is mapped differently in each round.

Round keys and mask bytes come from outside the core. Key expansion from the 256-bit key and the pseudo-random mask generator both sit elsewhere. The core drives a round index, and the surrounding logic must return that round's key and masks combinationally in the same cycle. A single-cycle start request loads the block and the direction. Busy stays high while the rounds run. A one-cycle done pulse marks the moment the result becomes valid on the output.

Top module: `dyn_sbox_aes_core`

## Requirements
- R1: When start is sampled high while idle, done goes high on the 14th rising edge after that one. The result is valid on block_out in the same cycle that done is high.
- R2: State byte i is taken from block bits [127-8i -: 8] and sits at row i mod 4, column i div 4. In each encrypt round r = 1..14, the core applies these steps in order: XOR with round_key, the masked substitution, the row shift, and then the column mix.
- R3: Round 14 of encryption has no column mix. There is no key addition after the last round.
- R4: In a round with masks p = mask_pre and q = mask_post, the substitution maps byte x to S(x XOR p) XOR q, where S is the AES forward S-box. Its inverse maps y to S⁻¹(y XOR q) XOR p.
- R5: The row shift rotates row r left by r byte positions. The column mix multiplies each column by the circulant matrix {02,03,01,01}. The inverse mix uses {0E,0B,0D,09}. Both work in GF(2^8) modulo 0x11B.
- R6: Decryption runs rounds 14 down to 1. Each round applies these steps in order: inverse mix (skipped in round 14), inverse row shift, inverse masked substitution, and then XOR with round_key.
- R7: While busy is high, round_idx steps by one each cycle: 1 up to 14 when encrypting, 14 down to 1 when decrypting. round_key and the mask bytes are sampled in the same cycle as the index they belong to.
- R8: A start request that arrives while busy is high is ignored. The running operation's result and timing are unchanged.
- R9: done is high for exactly one cycle. block_out holds its value until the next accepted start, whatever the other inputs do.
- R10: For any set of keys and masks, decrypting the ciphertext gives back the original plaintext.
- R11: After reset, busy, done, round_idx and block_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an operation; only acted on when the core is idle |
| decrypt | input | 1 | Direction sampled with start: 0 encrypt, 1 decrypt |
| block_in | input | 128 | Input block, sampled with start |
| round_key | input | 128 | Key for the round on round_idx |
| mask_pre | input | 8 | Byte XORed before the S-box in the current round |
| mask_post | input | 8 | Byte XORed after the S-box in the current round |
| round_idx | output | 4 | Current round number; 0 when idle |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| block_out | output | 128 | Result block |

## Verification
The bench uses several kinds of plaintext: all zeros, all ones, a byte ramp, a single set bit, and a sweep of all 256 values in the leading byte. These are run against four key and mask sets. One set has zero masks, which separates an error in the plain S-box from an error in the masking. Each ciphertext is compared with an arithmetic model, and each result is also decrypted again. The model and the round-trip together detect a wrong byte order, a wrong shift direction, mixing in round 14, swapped masks, and an index sequence that runs backwards. A second start request is injected in the middle of an operation, and the other inputs are changed while the core is idle. These two cases test that the core ignores a start while busy and holds its result when idle.

// File: rtl/dsa_pkg.sv
// Shared types and GF(2^8) arithmetic for the masked-round cipher core.
// Assumes state byte i = row (i mod 4), column (i div 4).
package dsa_pkg;
    localparam int NBYTES = 16;
    localparam int BW     = NBYTES * 8;

    typedef logic [7:0]              byte_t;
    typedef logic [NBYTES-1:0][7:0]  state_t;

    // multiply by x modulo 0x11B
    function automatic byte_t xt(input byte_t v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
    endfunction

    // general field multiply, shift-and-add
    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xt(p);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (0 maps to 0)
    function automatic byte_t ginv(input byte_t a);
        byte_t r;
        byte_t sq;
        r  = 8'h01;
        sq = a;
        for (int i = 1; i < 8; i++) begin
            sq = gmul(sq, sq);
            r  = gmul(r, sq);
        end
        return r;
    endfunction

    function automatic byte_t rotl(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (8 - n)));
    endfunction

    // forward S-box: inverse followed by affine map
    function automatic byte_t sbox_f(input byte_t x);
        byte_t b;
        b = ginv(x);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
    endfunction

    // inverse S-box: inverse affine map followed by field inverse
    function automatic byte_t sbox_i(input byte_t y);
        return ginv(rotl(y, 1) ^ rotl(y, 3) ^ rotl(y, 6) ^ 8'h05);
    endfunction

    function automatic state_t to_state(input logic [BW-1:0] v);
        state_t s;
        for (int i = 0; i < NBYTES; i++) s[i] = v[BW-1-8*i -: 8];
        return s;
    endfunction

    function automatic logic [BW-1:0] from_state(input state_t s);
        logic [BW-1:0] v;
        for (int i = 0; i < NBYTES; i++) v[BW-1-8*i -: 8] = s[i];
        return v;
    endfunction

    // row r rotated left by r columns
    function automatic state_t shift_f(input state_t s);
        state_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[4*c + r] = s[4*((c + r) % 4) + r];
        return o;
    endfunction

    // row r rotated right by r columns
    function automatic state_t shift_i(input state_t s);
        state_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[4*((c + r) % 4) + r] = s[4*c + r];
        return o;
    endfunction
endpackage

// File: rtl/dsa_sub_layer.sv
// Masked byte substitution across all state bytes.
// INV=0: S(x^pre)^post.  INV=1: S^-1(y^post)^pre.  Purely combinational.
module dsa_sub_layer import dsa_pkg::*; #(
    parameter bit INV = 1'b0
) (
    input  state_t din,
    input  byte_t  m_pre,
    input  byte_t  m_post,
    output state_t dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (!INV) begin : g_fwd
            // forward lookup with input and output masks
            assign dout[i] = sbox_f(din[i] ^ m_pre) ^ m_post;
        end else begin : g_inv
            // undo output mask, invert, undo input mask
            assign dout[i] = sbox_i(din[i] ^ m_post) ^ m_pre;
        end
    end
endmodule

// File: rtl/dsa_mix_layer.sv
// Column mix over the four state columns; INV selects the inverse matrix.
// Assumes column c holds bytes 4c..4c+3, row 0 first.  Combinational.
module dsa_mix_layer import dsa_pkg::*; #(
    parameter bit INV = 1'b0
) (
    input  state_t din,
    output state_t dout
);
    localparam byte_t C0 = INV ? 8'h0E : 8'h02;
    localparam byte_t C1 = INV ? 8'h0B : 8'h03;
    localparam byte_t C2 = INV ? 8'h0D : 8'h01;
    localparam byte_t C3 = INV ? 8'h09 : 8'h01;

    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            // circulant row of the matrix applied to one column
            assign dout[4*c + r] = gmul(din[4*c + r],           C0)
                                 ^ gmul(din[4*c + (r + 1) % 4], C1)
                                 ^ gmul(din[4*c + (r + 2) % 4], C2)
                                 ^ gmul(din[4*c + (r + 3) % 4], C3);
        end
    end
endmodule

// File: rtl/dsa_round_ctrl.sv
// Round sequencer: accepts start when idle, counts rounds up (encrypt) or
// down (decrypt), then pulses done.  Assumes ROUNDS >= 2.
module dsa_round_ctrl #(
    parameter int ROUNDS = 14,
    parameter int IW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          decrypt,
    output logic          busy,
    output logic          done,
    output logic          dec_q,
    output logic          load,
    output logic [IW-1:0] rnd
);
    logic last;

    // accepted start and final-round detection
    assign load = start && !busy;
    assign last = busy && (dec_q ? (rnd == IW'(1)) : (rnd == IW'(ROUNDS)));

    // sequence state: idle, stepping, finishing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            dec_q <= 1'b0;
            rnd   <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                dec_q <= decrypt;
                rnd   <= decrypt ? IW'(ROUNDS) : IW'(1);
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
                rnd  <= '0;
            end else if (busy) begin
                rnd <= dec_q ? rnd - 1'b1 : rnd + 1'b1;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && dec_q == $past(dec_q)));
    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd >= IW'(1) && rnd <= IW'(ROUNDS)));
    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (dec_q ? (rnd == IW'($past(rnd) - 1'b1))
                                   : (rnd == IW'($past(rnd) + 1'b1))));
endmodule

// File: rtl/dyn_sbox_aes_core.sv
// Iterative 128-bit cipher core with per-round masked substitution.
// One round per clock; round key and masks arrive combinationally for the
// index on round_idx.  Last encrypt round (and first decrypt round) skips mixing.
module dyn_sbox_aes_core import dsa_pkg::*; #(
    parameter  int ROUNDS = 14,
    localparam int IW     = $clog2(ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          decrypt,
    input  logic [BW-1:0] block_in,
    input  logic [BW-1:0] round_key,
    input  logic [7:0]    mask_pre,
    input  logic [7:0]    mask_post,
    output logic [IW-1:0] round_idx,
    output logic          busy,
    output logic          done,
    output logic [BW-1:0] block_out
);
    logic   dec_q, load, no_mix;
    state_t st_q, key_s, nxt;
    state_t e_key, e_sub, e_shf, e_mix, e_nxt;
    state_t d_mix, d_sel, d_shf, d_sub, d_nxt;

    dsa_round_ctrl #(.ROUNDS(ROUNDS), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .busy(busy), .done(done), .dec_q(dec_q), .load(load), .rnd(round_idx)
    );

    // key as bytes; round ROUNDS carries no mix in either direction
    assign key_s  = to_state(round_key);
    assign no_mix = (round_idx == IW'(ROUNDS));

    // encrypt path: key, substitute, shift, mix
    assign e_key = st_q ^ key_s;
    dsa_sub_layer #(.INV(1'b0)) u_sub_f (.din(e_key), .m_pre(mask_pre), .m_post(mask_post), .dout(e_sub));
    assign e_shf = shift_f(e_sub);
    dsa_mix_layer #(.INV(1'b0)) u_mix_f (.din(e_shf), .dout(e_mix));
    assign e_nxt = no_mix ? e_shf : e_mix;

    // decrypt path: inverse mix, inverse shift, inverse substitute, key
    dsa_mix_layer #(.INV(1'b1)) u_mix_i (.din(st_q), .dout(d_mix));
    assign d_sel = no_mix ? st_q : d_mix;
    assign d_shf = shift_i(d_sel);
    dsa_sub_layer #(.INV(1'b1)) u_sub_i (.din(d_shf), .m_pre(mask_pre), .m_post(mask_post), .dout(d_sub));
    assign d_nxt = d_sub ^ key_s;

    assign nxt = dec_q ? d_nxt : e_nxt;

    // state register: load block, then one round per busy cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= '0;
        else if (load)  st_q <= to_state(block_in);
        else if (busy)  st_q <= nxt;
    end

    assign block_out = from_state(st_q);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(block_out));
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && round_idx == '0));
endmodule

// File: tb/sim_dyn_sbox_aes_core.sv
module sim_dyn_sbox_aes_core;
    localparam int NR = 14;

    logic         clk = 1'b0;
    logic         rst_n, start, decrypt;
    logic [127:0] block_in, round_key, block_out;
    logic [7:0]   mask_pre, mask_post;
    logic [3:0]   round_idx;
    logic         busy, done;
    int           kset;
    int           nchk = 0, nfail = 0;
    bit           finished = 0;

    logic [7:0] ex[256];
    int         lg[256];
    logic [7:0] sb[256];
    logic [7:0] isb[256];

    always #10 clk = ~clk;

    dyn_sbox_aes_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .block_in(block_in), .round_key(round_key), .mask_pre(mask_pre),
        .mask_post(mask_post), .round_idx(round_idx), .busy(busy),
        .done(done), .block_out(block_out)
    );

    function automatic logic [127:0] key_of(int set, int r);
        logic [127:0] k;
        for (int w = 0; w < 4; w++)
            k[127-32*w -: 32] = (32'(r*4 + w + 1) * 32'h9E3779B9) ^ (32'(set) * 32'h85EBCA6B) ^ 32'(r);
        return k;
    endfunction
    function automatic logic [7:0] pre_of(int set, int r);
        return (set == 0) ? 8'h00 : 8'(r*37 + set*11 + 5);
    endfunction
    function automatic logic [7:0] post_of(int set, int r);
        return (set == 0) ? 8'h00 : (8'(r*91) ^ 8'(set*29) ^ 8'hA7);
    endfunction

    // key/mask store answering the round index port
    always_comb begin
        round_key = key_of(kset, int'(round_idx));
        mask_pre  = pre_of(kset, int'(round_idx));
        mask_post = post_of(kset, int'(round_idx));
    end

    function automatic logic [7:0] mulL(logic [7:0] a, logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return ex[(lg[a] + lg[b]) % 255];
    endfunction
    function automatic logic [7:0] gb(logic [127:0] v, int i);
        return v[127-8*i -: 8];
    endfunction

    function automatic logic [127:0] m_shift(logic [127:0] v, bit inv);
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                if (!inv) o[127-8*(4*c+r) -: 8] = gb(v, 4*((c+r)%4)+r);
                else      o[127-8*(4*((c+r)%4)+r) -: 8] = gb(v, 4*c+r);
        return o;
    endfunction
    function automatic logic [127:0] m_mix(logic [127:0] v, bit inv);
        logic [127:0] o;
        logic [7:0] k0, k1, k2, k3;
        k0 = inv ? 8'h0E : 8'h02; k1 = inv ? 8'h0B : 8'h03;
        k2 = inv ? 8'h0D : 8'h01; k3 = inv ? 8'h09 : 8'h01;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127-8*(4*c+r) -: 8] = mulL(gb(v,4*c+r),k0) ^ mulL(gb(v,4*c+(r+1)%4),k1)
                                      ^ mulL(gb(v,4*c+(r+2)%4),k2) ^ mulL(gb(v,4*c+(r+3)%4),k3);
        return o;
    endfunction
    function automatic logic [127:0] m_enc(logic [127:0] x, int set, bit mix_last);
        for (int r = 1; r <= NR; r++) begin
            x = x ^ key_of(set, r);
            for (int i = 0; i < 16; i++)
                x[127-8*i -: 8] = sb[gb(x,i) ^ pre_of(set,r)] ^ post_of(set,r);
            x = m_shift(x, 0);
            if (r < NR || mix_last) x = m_mix(x, 0);
        end
        return x;
    endfunction
    function automatic logic [127:0] m_dec(logic [127:0] x, int set);
        for (int r = NR; r >= 1; r--) begin
            if (r < NR) x = m_mix(x, 1);
            x = m_shift(x, 1);
            for (int i = 0; i < 16; i++)
                x[127-8*i -: 8] = isb[gb(x,i) ^ post_of(set,r)] ^ pre_of(set,r);
            x = x ^ key_of(set, r);
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one operation from start to done, with optional mid-run start at cycle inj
    task automatic run_op(input logic [127:0] blk, input logic dec, input int set, input int inj,
                          output logic [127:0] res, output int lat, output bit idx_ok, output bit pulse_ok);
        int cnt = 0;
        kset = set; block_in = blk; decrypt = dec; start = 1'b1;
        idx_ok = 1;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin start = 1'b0; block_in = ~blk; end
            if (cnt <= NR) begin
                if (!busy || int'(round_idx) != (dec ? NR + 1 - cnt : cnt)) idx_ok = 0;
            end
            if (inj != 0 && cnt == inj) begin start = 1'b1; block_in = ~blk; decrypt = ~dec; end
            if (inj != 0 && cnt == inj + 1) begin start = 1'b0; decrypt = dec; end
        end while (!done && cnt < 40);
        lat = cnt - 1;
        res = block_out;
        @(negedge clk);
        pulse_ok = !done && !busy && (block_out == res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [127:0] ct, pt, exp_c, r1, r2;
        logic [127:0] pats[4];
        int lat;
        bit iok, pok;

        // reference tables from generator 3
        ex[0] = 8'h01;
        for (int i = 1; i < 256; i++) ex[i] = ex[i-1] ^ ({ex[i-1][6:0],1'b0} ^ (ex[i-1][7] ? 8'h1B : 8'h00));
        for (int i = 0; i < 255; i++) lg[ex[i]] = i;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] b;
            b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
            sb[x] = b ^ {b[6:0],b[7]} ^ {b[5:0],b[7:6]} ^ {b[4:0],b[7:5]} ^ {b[3:0],b[7:4]} ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) isb[sb[x]] = 8'(x);

        rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; block_in = '1; kset = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && round_idx == 0 && block_out == 0, "R11 reset",
            {busy, done, round_idx, block_out[121:0]}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        pats[0] = 128'h0;
        pats[1] = '1;
        pats[2] = 128'h00112233445566778899AABBCCDDEEFF;
        pats[3] = 128'h1;
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                pt = pats[p];
                exp_c = m_enc(pt, s, 0);
                run_op(pt, 1'b0, s, 0, ct, lat, iok, pok);
                // R2/R4/R5 ciphertext against model
                chk(ct == exp_c, "R2/R4/R5 encrypt", ct, exp_c);
                chk(lat == NR, "R1 latency", 128'(lat), 128'(NR));
                chk(iok, "R7 ascending index", 128'(iok), 128'h1);
                chk(pok, "R9 done pulse", 128'(pok), 128'h1);
                run_op(ct, 1'b1, s, 0, r1, lat, iok, pok);
                chk(r1 == m_dec(ct, s), "R6 decrypt", r1, m_dec(ct, s));
                chk(r1 == pt, "R10 round trip", r1, pt);
                chk(iok, "R7 descending index", 128'(iok), 128'h1);
                chk(lat == NR, "R1 latency dec", 128'(lat), 128'(NR));
            end
        end

        // R3 no mix in round 14
        run_op(pats[2], 1'b0, 2, 0, ct, lat, iok, pok);
        chk(ct == m_enc(pats[2], 2, 0) && ct != m_enc(pats[2], 2, 1), "R3 final round", ct, m_enc(pats[2], 2, 0));

        // R4 masks change the mapping
        run_op(pats[2], 1'b0, 1, 0, r1, lat, iok, pok);
        run_op(pats[2], 1'b0, 3, 0, r2, lat, iok, pok);
        chk(r1 != r2, "R4 mask dependence", r1, ~r2);

        // R8 start while busy, encrypt and decrypt
        run_op(pats[2], 1'b0, 1, 5, ct, lat, iok, pok);
        chk(ct == r1 && lat == NR, "R8 ignored start enc", ct, r1);
        run_op(ct, 1'b1, 1, 9, pt, lat, iok, pok);
        chk(pt == pats[2] && lat == NR && iok, "R8 ignored start dec", pt, pats[2]);

        // R9 hold while idle and inputs move
        begin
            bit held = 1;
            for (int i = 0; i < 20; i++) begin
                kset = i % 4; block_in = 128'(i) * 128'h0123456789; decrypt = i[0];
                @(negedge clk);
                if (block_out != pt || done || busy) held = 0;
            end
            chk(held, "R9 idle hold", block_out, pt);
        end

        // sweep of the leading byte over all sets
        for (int v = 0; v < 256; v++) begin
            pt = {8'(v), 120'hA5A5_0F0F_3C3C_C3C3_5A5A_F0F0_96};
            exp_c = m_enc(pt, v % 4, 0);
            run_op(pt, 1'b0, v % 4, 0, ct, lat, iok, pok);
            chk(ct == exp_c, "R2 sweep encrypt", ct, exp_c);
            run_op(ct, 1'b1, v % 4, 0, r1, lat, iok, pok);
            chk(r1 == pt, "R10 sweep round trip", r1, pt);
        end

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule